// File: doc/BRIEF.md
# Non-Volatile Store Sequencer with Power-Up Recall

This block handles the persistence side of a bank of digitally set wipers. Each channel owns one volatile wiper register and a small set of data slots that model non-volatile storage. The command layer hands it a store request as a single-cycle pulse at the moment the serial frame closes. The request can write a host byte into one slot, copy one wiper into one of its own slots, or copy every wiper into the same slot index of its channel. A write-protect input blocks every store. A write-in-progress flag stays high for a programmable number of clock cycles, and requests that arrive while it is high are refused.

After a synchronous reset the data slots keep their contents. A recall sequencer then reads slot 0 of each channel, one channel per cycle, and loads it into that channel's wiper. Stores are locked out until a power-up delay has run and the recall has finished. Reads of the slots and direct wiper loads are accepted once the recall is done. The slot array uses one write port and one registered read port, so a block RAM can be inferred. All cycle times are counted in system clocks, which lets simulations use short values.

Top module: `nvstore_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `wip`, `st_rej`, `wr_ready`, `rd_vld` and `recall_done` are all 0.
- R2: After reset, every channel c loads its wiper from slot (c, 0), and `wiper_pos[c*DW +: DW]` shows that value. `recall_done` then rises and stays high until the next reset. Reset leaves the slot contents unchanged.
- R3: An accepted store raises `wip` on the edge that samples the request. `wip` then stays high for exactly max(WRITE_CYC, NUM_CH+1) cycles.
- R4: A store request sampled while `wp_n` is 0 is rejected. On the next cycle `st_rej` is 1, `wip` does not rise and no slot changes.
- R5: A store request sampled while `wip` is 1 is rejected in the same way.
- R6: `wr_ready` goes high only after PWRUP_CYC cycles have passed since reset and the recall is done. Until then every store request is rejected.
- R7: Op code 2'b00 writes `st_data` into slot (`st_ch`, `st_reg`).
- R8: Op code 2'b01 copies the wiper of `st_ch` into slot (`st_ch`, `st_reg`).
- R9: Op code 2'b10 copies the wiper of every channel c into slot (c, `st_reg`). The stored values are the wiper values present in the cycle the request is sampled.
- R10: Op code 2'b11 is reserved. A request with this op code is rejected.
- R11: Slot (c, r) has flat index i = c*NUM_DR + r and holds (i*INIT_MUL + INIT_ADD) mod 2^DW from time zero. A read request returns the slot on the next cycle with `rd_vld` = 1. Read requests made before `recall_done` are ignored (`rd_vld` stays 0).
- R12: After the recall, a wiper load request sets that channel's wiper. `wiper_pos` shows the new value on the second edge after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (models power-up) |
| wp_n | input | 1 | Write protect, low blocks all stores |
| st_valid | input | 1 | Store request pulse at frame end |
| st_op | input | 2 | Store op code |
| st_ch | input | CHW | Target channel |
| st_reg | input | RGW | Target slot index |
| st_data | input | DW | Host byte for op 2'b00 |
| wl_valid | input | 1 | Wiper load request |
| wl_ch | input | CHW | Wiper to load |
| wl_data | input | DW | Wiper value |
| rd_valid | input | 1 | Slot read request |
| rd_ch | input | CHW | Channel to read |
| rd_reg | input | RGW | Slot index to read |
| rd_data | output | DW | Read result |
| rd_vld | output | 1 | Read result valid |
| wiper_pos | output | NUM_CH*DW | Registered wiper positions, channel 0 in the low bits |
| recall_done | output | 1 | Power-up recall complete |
| wr_ready | output | 1 | Store lockout over |
| wip | output | 1 | Write in progress |
| st_rej | output | 1 | Previous cycle's store request was rejected |

## Verification
The checker watches the timing every cycle. It checks the exact length of each `wip` pulse and that `wip` only rises after a request. It checks that write-protect, busy, lockout and reserved op code each lead to a reject on the next cycle. It also checks that slot writes happen only under `wip`, that `recall_done` stays high, and that read results come only after permitted requests. Only the bench scenarios can show the data itself. These cover which slot holds which byte after each op code, that the global copy uses the wipers from the request cycle, that recalled wipers come from slot 0, and that stored data survives a second reset.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    OP_DATA_WR    = 2'b00,
    OP_WIPER_SAVE = 2'b01,
    OP_ALL_SAVE   = 2'b10,
    OP_RSVD       = 2'b11
  } store_op_e;
endpackage

// File: rtl/nvs_store_mem.sv
// Slot array: one write port, one registered read port, contents survive reset.
module nvs_store_mem #(
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter int INIT_MUL = 37,
  parameter int INIT_ADD = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * INIT_MUL + INIT_ADD);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvs_recall.sv
// Walks channels after reset, reading slot 0 of each and loading the wiper.
module nvs_recall #(
  parameter int NUM_CH = 4,
  parameter int NUM_DR = 4,
  parameter int DW     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic [$clog2(NUM_CH)+$clog2(NUM_DR)-1:0] rd_addr,
  input  logic [DW-1:0]             rd_data,
  output logic                      ld_en,
  output logic [$clog2(NUM_CH)-1:0] ld_ch,
  output logic [DW-1:0]             ld_data,
  output logic                      done
);
  localparam int CHW = $clog2(NUM_CH);
  localparam int RGW = $clog2(NUM_DR);

  logic [CHW:0]   issue_cnt;
  logic           issue;
  logic           pend_v;
  logic [CHW-1:0] pend_ch;

  assign issue   = issue_cnt < (CHW+1)'(NUM_CH);
  assign rd_addr = {issue_cnt[CHW-1:0], RGW'(0)};
  assign ld_en   = pend_v;
  assign ld_ch   = pend_ch;
  assign ld_data = rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_cnt <= '0;
      pend_v    <= 1'b0;
      pend_ch   <= '0;
      done      <= 1'b0;
    end else begin
      pend_v  <= issue;
      pend_ch <= issue_cnt[CHW-1:0];
      if (issue) issue_cnt <= issue_cnt + 1'b1;
      if (pend_v && pend_ch == CHW'(NUM_CH-1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/nvs_wiper_bank.sv
// Volatile wiper registers with registered position outputs.
module nvs_wiper_bank #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rc_en,
  input  logic [$clog2(NUM_CH)-1:0] rc_ch,
  input  logic [DW-1:0]             rc_data,
  input  logic                      wl_en,
  input  logic [$clog2(NUM_CH)-1:0] wl_ch,
  input  logic [DW-1:0]             wl_data,
  output logic [NUM_CH*DW-1:0]      wiper_vec,
  output logic [NUM_CH*DW-1:0]      wiper_pos
);
  localparam int CHW = $clog2(NUM_CH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DW-1:0] w_q;
    logic [DW-1:0] pos_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        w_q   <= '0;
        pos_q <= '0;
      end else begin
        if (rc_en && rc_ch == CHW'(g))      w_q <= rc_data;
        else if (wl_en && wl_ch == CHW'(g)) w_q <= wl_data;
        pos_q <= w_q;
      end
    end

    assign wiper_vec[g*DW +: DW] = w_q;
    assign wiper_pos[g*DW +: DW] = pos_q;
  end
endmodule

// File: rtl/nvs_store_ctl.sv
// Accepts or rejects stores, holds the busy flag, drives the slot write port.
module nvs_store_ctl
  import nvs_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_DR    = 4,
  parameter int DW        = 8,
  parameter int WRITE_CYC = 12,
  parameter int PWRUP_CYC = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wp_n,
  input  logic                      recall_done,
  input  logic                      st_valid,
  input  logic [1:0]                st_op,
  input  logic [$clog2(NUM_CH)-1:0] st_ch,
  input  logic [$clog2(NUM_DR)-1:0] st_reg,
  input  logic [DW-1:0]             st_data,
  input  logic [NUM_CH*DW-1:0]      wiper_vec,
  output logic                      mem_we,
  output logic [$clog2(NUM_CH)+$clog2(NUM_DR)-1:0] mem_waddr,
  output logic [DW-1:0]             mem_wdata,
  output logic                      wip,
  output logic                      st_rej,
  output logic                      wr_ready
);
  localparam int CHW      = $clog2(NUM_CH);
  localparam int RGW      = $clog2(NUM_DR);
  localparam int BUSY_CYC = (WRITE_CYC > NUM_CH + 1) ? WRITE_CYC : NUM_CH + 1;
  localparam int CW       = $clog2(BUSY_CYC);
  localparam int PW       = $clog2(PWRUP_CYC + 1);

  store_op_e           op;
  logic                accept;
  logic [PW-1:0]       pu_cnt;
  logic [CW-1:0]       busy_cnt;
  logic [CHW:0]        q_left;
  logic [CHW-1:0]      q_ch;
  logic [RGW-1:0]      q_reg;
  logic                q_use_data;
  logic [DW-1:0]       q_data;
  logic [NUM_CH*DW-1:0] snap;

  assign op     = store_op_e'(st_op);
  assign accept = st_valid && wr_ready && !wip && wp_n && (op != OP_RSVD);

  // power-up lockout counter
  always_ff @(posedge clk) begin
    if (rst) begin
      pu_cnt   <= '0;
      wr_ready <= 1'b0;
    end else begin
      if (pu_cnt != PW'(PWRUP_CYC)) pu_cnt <= pu_cnt + 1'b1;
      wr_ready <= (pu_cnt == PW'(PWRUP_CYC)) && recall_done;
    end
  end

  // busy flag and write queue
  always_ff @(posedge clk) begin
    if (rst) begin
      wip        <= 1'b0;
      st_rej     <= 1'b0;
      busy_cnt   <= '0;
      q_left     <= '0;
      q_ch       <= '0;
      q_reg      <= '0;
      q_use_data <= 1'b0;
      q_data     <= '0;
      snap       <= '0;
    end else begin
      st_rej <= st_valid && !accept;
      if (accept) begin
        wip        <= 1'b1;
        busy_cnt   <= CW'(BUSY_CYC - 1);
        q_left     <= (op == OP_ALL_SAVE) ? (CHW+1)'(NUM_CH) : (CHW+1)'(1);
        q_ch       <= (op == OP_ALL_SAVE) ? '0 : st_ch;
        q_reg      <= st_reg;
        q_use_data <= (op == OP_DATA_WR);
        q_data     <= st_data;
        snap       <= wiper_vec;
      end else begin
        if (q_left != '0) begin
          q_left <= q_left - 1'b1;
          q_ch   <= q_ch + 1'b1;
        end
        if (wip) begin
          if (busy_cnt == '0) wip <= 1'b0;
          else                busy_cnt <= busy_cnt - 1'b1;
        end
      end
    end
  end

  assign mem_we    = (q_left != '0);
  assign mem_waddr = {q_ch, q_reg};
  assign mem_wdata = q_use_data ? q_data : snap[q_ch*DW +: DW];
endmodule

// File: rtl/nvstore_seq.sv
module nvstore_seq #(
  parameter int NUM_CH    = 4,
  parameter int NUM_DR    = 4,
  parameter int DW        = 8,
  parameter int WRITE_CYC = 12,
  parameter int PWRUP_CYC = 20,
  parameter int INIT_MUL  = 37,
  parameter int INIT_ADD  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wp_n,
  input  logic                      st_valid,
  input  logic [1:0]                st_op,
  input  logic [$clog2(NUM_CH)-1:0] st_ch,
  input  logic [$clog2(NUM_DR)-1:0] st_reg,
  input  logic [DW-1:0]             st_data,
  input  logic                      wl_valid,
  input  logic [$clog2(NUM_CH)-1:0] wl_ch,
  input  logic [DW-1:0]             wl_data,
  input  logic                      rd_valid,
  input  logic [$clog2(NUM_CH)-1:0] rd_ch,
  input  logic [$clog2(NUM_DR)-1:0] rd_reg,
  output logic [DW-1:0]             rd_data,
  output logic                      rd_vld,
  output logic [NUM_CH*DW-1:0]      wiper_pos,
  output logic                      recall_done,
  output logic                      wr_ready,
  output logic                      wip,
  output logic                      st_rej
);
  localparam int CHW = $clog2(NUM_CH);
  localparam int RGW = $clog2(NUM_DR);
  localparam int AW  = CHW + RGW;

  logic                 mem_we;
  logic [AW-1:0]        mem_waddr;
  logic [DW-1:0]        mem_wdata;
  logic [AW-1:0]        mem_raddr;
  logic [DW-1:0]        mem_rdata;
  logic [AW-1:0]        rc_addr;
  logic                 rc_en;
  logic [CHW-1:0]       rc_ch;
  logic [DW-1:0]        rc_data;
  logic [NUM_CH*DW-1:0] wiper_vec;

  assign mem_raddr = recall_done ? {rd_ch, rd_reg} : rc_addr;
  assign rd_data   = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= rd_valid && recall_done;
  end

  nvs_store_mem #(
    .DW(DW), .AW(AW), .INIT_MUL(INIT_MUL), .INIT_ADD(INIT_ADD)
  ) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  nvs_recall #(
    .NUM_CH(NUM_CH), .NUM_DR(NUM_DR), .DW(DW)
  ) recall_i (
    .clk(clk), .rst(rst), .rd_addr(rc_addr), .rd_data(mem_rdata),
    .ld_en(rc_en), .ld_ch(rc_ch), .ld_data(rc_data), .done(recall_done)
  );

  nvs_wiper_bank #(
    .NUM_CH(NUM_CH), .DW(DW)
  ) wipers_i (
    .clk(clk), .rst(rst),
    .rc_en(rc_en), .rc_ch(rc_ch), .rc_data(rc_data),
    .wl_en(wl_valid && recall_done), .wl_ch(wl_ch), .wl_data(wl_data),
    .wiper_vec(wiper_vec), .wiper_pos(wiper_pos)
  );

  nvs_store_ctl #(
    .NUM_CH(NUM_CH), .NUM_DR(NUM_DR), .DW(DW),
    .WRITE_CYC(WRITE_CYC), .PWRUP_CYC(PWRUP_CYC)
  ) ctl_i (
    .clk(clk), .rst(rst), .wp_n(wp_n), .recall_done(recall_done),
    .st_valid(st_valid), .st_op(st_op), .st_ch(st_ch), .st_reg(st_reg),
    .st_data(st_data), .wiper_vec(wiper_vec),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wip(wip), .st_rej(st_rej), .wr_ready(wr_ready)
  );
endmodule

// File: rtl/nvstore_seq_chk.sv
module nvstore_seq_chk #(
  parameter int NUM_CH    = 4,
  parameter int WRITE_CYC = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       wp_n,
  input logic       st_valid,
  input logic [1:0] st_op,
  input logic       wip,
  input logic       st_rej,
  input logic       wr_ready,
  input logic       recall_done,
  input logic       rd_valid,
  input logic       rd_vld,
  input logic       mem_we
);
  localparam int BUSY_CYC = (WRITE_CYC > NUM_CH + 1) ? WRITE_CYC : NUM_CH + 1;

  int run_q;
  always_ff @(posedge clk) begin
    if (rst)      run_q <= 0;
    else if (wip) run_q <= run_q + 1;
    else          run_q <= 0;
  end

  // R3
  wip_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> run_q == BUSY_CYC);
  // R3
  wip_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(st_valid));
  // R4
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !wp_n) |=> (st_rej && !$rose(wip)));
  // R5
  busy_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && wip) |=> st_rej);
  // R6
  lock_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !wr_ready) |=> st_rej);
  // R6
  ready_order_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> recall_done);
  // R10
  rsvd_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_op == 2'b11) |=> st_rej);
  // R2
  recall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    recall_done |=> recall_done);
  // R11
  rd_vld_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(rd_valid && recall_done));
  // R7
  mem_we_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wip);
endmodule

bind nvstore_seq nvstore_seq_chk #(.NUM_CH(NUM_CH), .WRITE_CYC(WRITE_CYC)) chk_i (
  .clk(clk), .rst(rst), .wp_n(wp_n), .st_valid(st_valid), .st_op(st_op),
  .wip(wip), .st_rej(st_rej), .wr_ready(wr_ready), .recall_done(recall_done),
  .rd_valid(rd_valid), .rd_vld(rd_vld), .mem_we(mem_we)
);

// File: tb/nvstore_seq_tb.sv
module nvstore_seq_tb_top;
  localparam int NCH = 4, NDR = 4, DW = 8, WCYC = 12, PCYC = 20;
  localparam int MUL = 37, ADD = 5;
  localparam int BUSY = (WCYC > NCH + 1) ? WCYC : NCH + 1;

  logic clk = 1'b0, rst = 1'b1, wp_n = 1'b1;
  logic st_valid = 1'b0; logic [1:0] st_op = '0; logic [1:0] st_ch = '0;
  logic [1:0] st_reg = '0; logic [7:0] st_data = '0;
  logic wl_valid = 1'b0; logic [1:0] wl_ch = '0; logic [7:0] wl_data = '0;
  logic rd_valid = 1'b0; logic [1:0] rd_ch = '0; logic [1:0] rd_reg = '0;
  logic [7:0] rd_data; logic rd_vld;
  logic [NCH*DW-1:0] wiper_pos;
  logic recall_done, wr_ready, wip, st_rej;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_dr [NCH*NDR];
  logic [7:0] exp_w [NCH];

  always #4 clk = ~clk;

  nvstore_seq #(.NUM_CH(NCH), .NUM_DR(NDR), .DW(DW), .WRITE_CYC(WCYC),
                .PWRUP_CYC(PCYC), .INIT_MUL(MUL), .INIT_ADD(ADD)) dut_i (
    .clk(clk), .rst(rst), .wp_n(wp_n), .st_valid(st_valid), .st_op(st_op),
    .st_ch(st_ch), .st_reg(st_reg), .st_data(st_data), .wl_valid(wl_valid),
    .wl_ch(wl_ch), .wl_data(wl_data), .rd_valid(rd_valid), .rd_ch(rd_ch),
    .rd_reg(rd_reg), .rd_data(rd_data), .rd_vld(rd_vld), .wiper_pos(wiper_pos),
    .recall_done(recall_done), .wr_ready(wr_ready), .wip(wip), .st_rej(st_rej));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic wait_recall();
    int t = 0;
    while (recall_done !== 1'b1 && t < 200) begin @(negedge clk); t++; end
    chk(recall_done === 1'b1, "R2 recall_done", recall_done, 1);
  endtask

  task automatic check_wipers(input string req);
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCH; c++)
      chk(wiper_pos[c*DW +: DW] === exp_w[c], req, wiper_pos[c*DW +: DW], exp_w[c]);
  endtask

  task automatic rd_chk(input int c, input int r, input string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_ch = 2'(c); rd_reg = 2'(r);
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_vld === 1'b1 && rd_data === exp_dr[c*NDR+r], req, rd_data, exp_dr[c*NDR+r]);
  endtask

  task automatic rd_all(input string req);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NDR; r++) rd_chk(c, r, req);
  endtask

  task automatic wload(input int c, input logic [7:0] v);
    @(negedge clk);
    wl_valid = 1'b1; wl_ch = 2'(c); wl_data = v;
    @(negedge clk);
    wl_valid = 1'b0;
    exp_w[c] = v;
  endtask

  // returns after wip has dropped (accepted) or after the reject sample
  task automatic store(input logic [1:0] op, input int c, input int r,
                       input logic [7:0] d, input bit acc, input string req);
    int n = 0;
    @(negedge clk);
    st_valid = 1'b1; st_op = op; st_ch = 2'(c); st_reg = 2'(r); st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
    if (acc) begin
      chk(wip === 1'b1 && st_rej === 1'b0, req, {wip, st_rej}, 2'b10);
      while (wip === 1'b1 && n < 1000) begin n++; @(negedge clk); end
      chk(n == BUSY, "R3 wip length", n, BUSY);
    end else begin
      chk(st_rej === 1'b1 && wip === 1'b0, req, {wip, st_rej}, 2'b01);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH*NDR; i++) exp_dr[i] = 8'(i * MUL + ADD);

    // R1 reset state
    repeat (4) @(negedge clk);
    chk({wip, st_rej, wr_ready, rd_vld, recall_done} === 5'b0, "R1 reset outputs",
        {wip, st_rej, wr_ready, rd_vld, recall_done}, 0);
    rst = 1'b0;
    // R11 read ignored during recall
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_vld === 1'b0, "R11 read during recall", rd_vld, 0);
    chk(wip === 1'b0 && wr_ready === 1'b0, "R1 after reset", {wip, wr_ready}, 0);

    // R2 recall from slot 0
    wait_recall();
    for (int c = 0; c < NCH; c++) exp_w[c] = exp_dr[c*NDR];
    check_wipers("R2 recalled wiper");

    // R6 lockout before power-up delay
    store(2'b00, 1, 2, 8'hEE, 1'b0, "R6 store in lockout");
    rd_chk(1, 2, "R6 slot unchanged after lockout reject");
    // R11 initial contents sweep
    rd_all("R11 initial slot");
    begin
      int t = 0;
      while (wr_ready !== 1'b1 && t < 200) begin @(negedge clk); t++; end
      chk(wr_ready === 1'b1, "R6 wr_ready", wr_ready, 1);
    end

    // R7 exhaustive data writes
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NDR; r++) begin
        logic [7:0] v = 8'((c*16 + r) ^ 8'hA5);
        store(2'b00, c, r, v, 1'b1, "R7 data write accept");
        exp_dr[c*NDR+r] = v;
      end
    rd_all("R7 data write readback");

    // R5 busy reject
    @(negedge clk);
    st_valid = 1'b1; st_op = 2'b00; st_ch = 2'd1; st_reg = 2'd1; st_data = 8'h3C;
    @(negedge clk);
    st_ch = 2'd2; st_reg = 2'd2; st_data = 8'hC3;
    @(negedge clk);
    st_valid = 1'b0;
    chk(st_rej === 1'b1 && wip === 1'b1, "R5 busy reject", {wip, st_rej}, 2'b11);
    exp_dr[1*NDR+1] = 8'h3C;
    begin
      int t = 0;
      while (wip === 1'b1 && t < 100) begin @(negedge clk); t++; end
    end
    rd_chk(1, 1, "R5 first store landed");
    rd_chk(2, 2, "R5 rejected store no effect");

    // R4 write protect
    wp_n = 1'b0;
    store(2'b00, 0, 0, 8'hFF, 1'b0, "R4 protected data write");
    store(2'b10, 0, 3, 8'h00, 1'b0, "R4 protected global store");
    wp_n = 1'b1;
    rd_chk(0, 0, "R4 slot unchanged");
    rd_chk(2, 3, "R4 slot unchanged");

    // R10 reserved op
    store(2'b11, 3, 3, 8'h11, 1'b0, "R10 reserved op");
    rd_chk(3, 3, "R10 slot unchanged");

    // R12 wiper load and R8 single copy
    wload(3, 8'h5A);
    check_wipers("R12 wiper load");
    store(2'b01, 3, 1, 8'h00, 1'b1, "R8 wiper copy accept");
    exp_dr[3*NDR+1] = 8'h5A;
    rd_chk(3, 1, "R8 wiper copied");
    rd_chk(3, 0, "R8 neighbour unchanged");

    // R9 global copy with snapshot
    for (int c = 0; c < NCH; c++) wload(c, 8'(8'h10 + c*8'h11));
    @(negedge clk);
    st_valid = 1'b1; st_op = 2'b10; st_ch = 2'd3; st_reg = 2'd2;
    @(negedge clk);
    st_valid = 1'b0;
    chk(wip === 1'b1, "R9 global accept", wip, 1);
    wl_valid = 1'b1; wl_ch = 2'd0; wl_data = 8'h99;
    @(negedge clk);
    wl_valid = 1'b0;
    for (int c = 0; c < NCH; c++) exp_dr[c*NDR+2] = exp_w[c];
    exp_w[0] = 8'h99;
    begin
      int t = 0;
      while (wip === 1'b1 && t < 100) begin @(negedge clk); t++; end
    end
    for (int c = 0; c < NCH; c++) rd_chk(c, 2, "R9 global snapshot slot");
    check_wipers("R12 wiper after global");
    rd_all("R9 full readback");

    // R2 second reset: slots persist, wipers recalled
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(wiper_pos === '0, "R2 wipers volatile in reset", wiper_pos, 0);
    rst = 1'b0;
    wait_recall();
    for (int c = 0; c < NCH; c++) exp_w[c] = exp_dr[c*NDR];
    check_wipers("R2 recall after rewrite");
    rd_all("R2 slots persist across reset");

    summary();
    $finish;
  end
endmodule